// File: doc/BRIEF.md
# Address Translation Cache with Page-Table Walker

This block converts 32-bit virtual addresses into 29-bit physical addresses for a requester such as a processor load/store stage. It keeps a small set of recently used page translations. Each held entry is compared against the incoming virtual page number at the same time. On a hit, the physical page number is joined to the untranslated 12-bit page offset and returned one cycle later.

On a miss, the block holds the requester with a stall flag and fetches the needed entry from a flat page table in main memory. The table has one 32-bit word per virtual page. The word's address is a programmable base plus four times the virtual page number. A fetched entry whose resident flag is clear is not cached; the block reports a page fault instead, and software is expected to handle it. Writes keep the page's dirty flag current, both in the cached copy and in the table in memory.

The requester holds `req_valid` and its address and direction steady until `rsp_ready` or `rsp_fault` pulses for one cycle. Inputs are ignored during that pulse cycle. The memory port holds `mem_req` and its fields until `mem_ack` is high for one cycle, and read data is valid with that acknowledge.

Top module: `addr_xlate`

## Requirements
- R1: A completed translation drives `rsp_paddr[11:0]` with `req_vaddr[11:0]` and `rsp_paddr[28:12]` with the physical page number of the page `req_vaddr[31:12]`.
- R2: A read hit, or a write hit to a page already dirty, raises `rsp_ready` for exactly one cycle on the clock edge after the request is first sampled. It makes no memory access and never raises `rsp_stall`.
- R3: On a miss the block issues a single memory read at address `{base[31:2],2'b00} + 4*VPN`. `rsp_stall` is high from the edge after the request is sampled until the response edge, where it drops.
- R4: Table word layout: bit 31 is resident, bit 30 is dirty, bits 16:0 are the physical page number (or disk page address), and bits 29:17 are ignored. A resident word is installed, so the next access to the page hits.
- R5: A fetched word with bit 31 clear pulses `rsp_fault` for one cycle without `rsp_ready` and is not installed, so a repeat access walks again.
- R6: A write to a page whose cached or fetched dirty flag is clear marks the entry dirty. Before `rsp_ready`, it also writes `{2'b11, 13'b0, PPN}` to the page's table word. A write to a dirty page writes nothing.
- R7: A refill uses the lowest-numbered invalid entry if one exists. Otherwise it uses a round-robin pointer that starts at entry 0 after reset and advances after each replacement of a valid entry.
- R8: `flush` clears every entry in one cycle. If it coincides with a refill install, the flush wins and the page is not retained.
- R9: After reset, all outputs are low, every entry is invalid and the base is zero.
- R10: Only one memory request is outstanding at a time. While `mem_req` is high without `mem_ack`, the request and its address and direction stay unchanged.
- R11: `base_we` loads the table base from `base_val[31:2]`. The two low bits are treated as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all cached translations |
| base_we | input | 1 | Load the page-table base |
| base_val | input | 32 | New page-table base (word aligned) |
| req_valid | input | 1 | Translation request present |
| req_write | input | 1 | Request is a store |
| req_vaddr | input | 32 | Virtual address |
| rsp_ready | output | 1 | One-cycle pulse: translation complete |
| rsp_fault | output | 1 | One-cycle pulse: page not resident |
| rsp_stall | output | 1 | Requester must wait (walk or write-back in progress) |
| rsp_paddr | output | 29 | Physical address, valid with `rsp_ready` |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Byte address of the table word |
| mem_wdata | output | 32 | Table word to write |
| mem_ack | input | 1 | Memory access complete |
| mem_rdata | input | 32 | Table word read, valid with `mem_ack` |

## Verification
Two functions can meet on the same clock edge: a flush and the installation of a freshly fetched entry. The bench raises `flush` exactly in the cycle its memory model returns `mem_ack` for a walk. It then judges the outcome at the ports: the next access to the same page must start a second table read, and the access after that must hit. The replacement order is also judged by counting table reads over a sequence that overfills the entries. The dirty write-back is judged by the number of memory writes and the word left in the bench's table.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
  // Table word flag positions (decoded by software and by the walker)
  localparam int PTE_RES_BIT   = 31;
  localparam int PTE_DIRTY_BIT = 30;

  typedef enum logic [1:0] {
    ST_LOOK = 2'd0,
    ST_WALK = 2'd1,
    ST_WB   = 2'd2,
    ST_RESP = 2'd3
  } xlt_state_e;
endpackage

// File: rtl/xlt_cam.sv
module xlt_cam #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 17,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flush,
  input  logic [VPN_W-1:0]   lk_vpn,
  output logic               hit,
  output logic [IDX_W-1:0]   hit_idx,
  output logic [PPN_W-1:0]   hit_ppn,
  output logic               hit_dirty,
  output logic [ENTRIES-1:0] valid_vec,
  input  logic               ins_en,
  input  logic [IDX_W-1:0]   ins_idx,
  input  logic [VPN_W-1:0]   ins_vpn,
  input  logic [PPN_W-1:0]   ins_ppn,
  input  logic               ins_dirty,
  input  logic               dset_en,
  input  logic [IDX_W-1:0]   dset_idx
);
  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] dirty_q;
  logic [VPN_W-1:0]   tag_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q [ENTRIES];
  logic [ENTRIES-1:0] match;

  // Flush beats a same-cycle install
  always_ff @(posedge clk) begin
    if (rst || flush) valid_q <= '0;
    else if (ins_en)  valid_q[ins_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (ins_en) dirty_q[ins_idx] <= ins_dirty;
    if (dset_en) dirty_q[dset_idx] <= 1'b1;
  end

  // Tag/data storage without reset so it can map to distributed RAM
  always_ff @(posedge clk) begin
    if (ins_en) begin
      tag_q[ins_idx] <= ins_vpn;
      ppn_q[ins_idx] <= ins_ppn;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = valid_q[g] && (tag_q[g] == lk_vpn);
  end

  // At most one entry matches, so OR-combining gives the selected fields
  always_comb begin
    hit_idx   = '0;
    hit_ppn   = '0;
    hit_dirty = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) begin
        hit_idx   = hit_idx | IDX_W'(i);
        hit_ppn   = hit_ppn | ppn_q[i];
        hit_dirty = hit_dirty | dirty_q[i];
      end
    end
  end

  assign hit       = |match;
  assign valid_vec = valid_q;
endmodule

// File: rtl/xlt_victim.sv
module xlt_victim #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic               take,
  output logic [IDX_W-1:0]   slot
);
  logic [IDX_W-1:0] rr_q;
  logic             all_full;

  assign all_full = &valid_vec;

  always_comb begin
    slot = rr_q;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) slot = IDX_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rr_q <= '0;
    else if (take && all_full)
      rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
  end
endmodule

// File: rtl/addr_xlate.sv
module addr_xlate
  import xlt_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int PA_W    = 29,
  parameter int OFS_W   = 12,
  parameter int MA_W    = 32,
  parameter int ENTRIES = 8,
  localparam int VPN_W  = VA_W - OFS_W,
  localparam int PPN_W  = PA_W - OFS_W,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            flush,
  input  logic            base_we,
  input  logic [MA_W-1:0] base_val,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [VA_W-1:0] req_vaddr,
  output logic            rsp_ready,
  output logic            rsp_fault,
  output logic            rsp_stall,
  output logic [PA_W-1:0] rsp_paddr,
  output logic            mem_req,
  output logic            mem_we,
  output logic [MA_W-1:0] mem_addr,
  output logic [MA_W-1:0] mem_wdata,
  input  logic            mem_ack,
  input  logic [MA_W-1:0] mem_rdata
);
  xlt_state_e        state_q;
  logic [MA_W-3:0]   base_q;
  logic [OFS_W-1:0]  cur_ofs_q;
  logic              cur_wr_q;
  logic [VPN_W-1:0]  cur_vpn_q;
  logic [PPN_W-1:0]  cur_ppn_q;

  logic [VPN_W-1:0]  lk_vpn;
  logic              hit, hit_dirty;
  logic [IDX_W-1:0]  hit_idx, victim;
  logic [PPN_W-1:0]  hit_ppn;
  logic [ENTRIES-1:0] valid_vec;
  logic              ins_en, dset_en;
  logic              pte_res, pte_dirty;
  logic [PPN_W-1:0]  pte_ppn;
  logic [MA_W-1:0]   walk_addr;
  logic              unused_pte_bits;

  assign lk_vpn    = req_vaddr[VA_W-1:OFS_W];
  assign walk_addr = {base_q, 2'b00} + MA_W'({lk_vpn, 2'b00});
  assign pte_res   = mem_rdata[PTE_RES_BIT];
  assign pte_dirty = mem_rdata[PTE_DIRTY_BIT];
  assign pte_ppn   = mem_rdata[PPN_W-1:0];
  assign unused_pte_bits = ^{mem_rdata[PTE_DIRTY_BIT-1:PPN_W], base_val[1:0]};

  assign ins_en  = (state_q == ST_WALK) && mem_ack && pte_res;
  assign dset_en = (state_q == ST_LOOK) && req_valid && hit && req_write && !hit_dirty;

  xlt_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_cam (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .lk_vpn    (lk_vpn),
    .hit       (hit),
    .hit_idx   (hit_idx),
    .hit_ppn   (hit_ppn),
    .hit_dirty (hit_dirty),
    .valid_vec (valid_vec),
    .ins_en    (ins_en),
    .ins_idx   (victim),
    .ins_vpn   (cur_vpn_q),
    .ins_ppn   (pte_ppn),
    .ins_dirty (pte_dirty | cur_wr_q),
    .dset_en   (dset_en),
    .dset_idx  (hit_idx)
  );

  xlt_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk       (clk),
    .rst       (rst),
    .valid_vec (valid_vec),
    .take      (ins_en),
    .slot      (victim)
  );

  always_ff @(posedge clk) begin
    if (rst) base_q <= '0;
    else if (base_we) base_q <= base_val[MA_W-1:2];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_LOOK;
      rsp_ready <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_stall <= 1'b0;
      rsp_paddr <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      cur_ofs_q <= '0;
      cur_wr_q  <= 1'b0;
      cur_vpn_q <= '0;
      cur_ppn_q <= '0;
    end else begin
      case (state_q)
        ST_LOOK: begin
          if (req_valid) begin
            cur_ofs_q <= req_vaddr[OFS_W-1:0];
            cur_wr_q  <= req_write;
            cur_vpn_q <= lk_vpn;
            cur_ppn_q <= hit_ppn;
            mem_addr  <= walk_addr;
            if (hit && !(req_write && !hit_dirty)) begin
              rsp_ready <= 1'b1;
              rsp_paddr <= {hit_ppn, req_vaddr[OFS_W-1:0]};
              state_q   <= ST_RESP;
            end else if (hit) begin
              mem_req   <= 1'b1;
              mem_we    <= 1'b1;
              mem_wdata <= {2'b11, {(MA_W-2-PPN_W){1'b0}}, hit_ppn};
              rsp_stall <= 1'b1;
              state_q   <= ST_WB;
            end else begin
              mem_req   <= 1'b1;
              mem_we    <= 1'b0;
              rsp_stall <= 1'b1;
              state_q   <= ST_WALK;
            end
          end
        end
        ST_WALK: begin
          if (mem_ack) begin
            cur_ppn_q <= pte_ppn;
            if (!pte_res) begin
              mem_req   <= 1'b0;
              rsp_fault <= 1'b1;
              rsp_stall <= 1'b0;
              state_q   <= ST_RESP;
            end else if (cur_wr_q && !pte_dirty) begin
              mem_req   <= 1'b1;
              mem_we    <= 1'b1;
              mem_wdata <= {2'b11, {(MA_W-2-PPN_W){1'b0}}, pte_ppn};
              state_q   <= ST_WB;
            end else begin
              mem_req   <= 1'b0;
              rsp_ready <= 1'b1;
              rsp_stall <= 1'b0;
              rsp_paddr <= {pte_ppn, cur_ofs_q};
              state_q   <= ST_RESP;
            end
          end
        end
        ST_WB: begin
          if (mem_ack) begin
            mem_req   <= 1'b0;
            mem_we    <= 1'b0;
            rsp_ready <= 1'b1;
            rsp_stall <= 1'b0;
            rsp_paddr <= {cur_ppn_q, cur_ofs_q};
            state_q   <= ST_RESP;
          end
        end
        default: begin
          rsp_ready <= 1'b0;
          rsp_fault <= 1'b0;
          state_q   <= ST_LOOK;
        end
      endcase
    end
  end
endmodule

// File: rtl/xlt_checker.sv
module xlt_checker #(
  parameter int PA_W = 29,
  parameter int MA_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            rsp_ready,
  input logic            rsp_fault,
  input logic            rsp_stall,
  input logic [PA_W-1:0] rsp_paddr,
  input logic            mem_req,
  input logic            mem_we,
  input logic [MA_W-1:0] mem_addr,
  input logic [MA_W-1:0] mem_wdata,
  input logic            mem_ack
);
  p_fault_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(rsp_ready && rsp_fault));

  p_ready_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    rsp_ready |=> !rsp_ready);

  p_fault_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |=> !rsp_fault);

  p_stall_drop_r3: assert property (@(posedge clk) disable iff (rst)
    (rsp_ready || rsp_fault) |-> !rsp_stall);

  p_mem_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  p_mem_during_stall_r3: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> rsp_stall);

  p_wb_flags_r6: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (mem_wdata[31] && mem_wdata[30]));

  p_word_align_r11: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  p_reset_quiet_r9: assert property (@(posedge clk)
    ($past(rst) && !rst) |-> (!rsp_ready && !rsp_fault && !rsp_stall && !mem_req
                              && (rsp_paddr == '0)));
endmodule

bind addr_xlate xlt_checker #(.PA_W(PA_W), .MA_W(MA_W)) u_xlt_checker (
  .clk       (clk),
  .rst       (rst),
  .rsp_ready (rsp_ready),
  .rsp_fault (rsp_fault),
  .rsp_stall (rsp_stall),
  .rsp_paddr (rsp_paddr),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_ack   (mem_ack)
);

// File: tb/test_addr_xlate.sv
module test_addr_xlate;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flush = 1'b0;
  logic        base_we = 1'b0;
  logic [31:0] base_val = '0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        rsp_ready, rsp_fault, rsp_stall;
  logic [28:0] rsp_paddr;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  int n_tests = 0;
  int n_fail  = 0;
  int n_rd = 0;
  int n_wr = 0;
  logic [31:0] last_rd_addr = '0;
  logic [31:0] pt_mem [logic [31:0]];
  bit done = 1'b0;

  localparam logic [31:0] BASE  = 32'h0008_0000;
  localparam logic [19:0] V0    = 20'h00010;
  localparam logic [19:0] VFLT  = 20'h00666;

  always #2 clk = ~clk;   // 250 MHz

  addr_xlate i_addr_xlate (
    .clk(clk), .rst(rst), .flush(flush), .base_we(base_we), .base_val(base_val),
    .req_valid(req_valid), .req_write(req_write), .req_vaddr(req_vaddr),
    .rsp_ready(rsp_ready), .rsp_fault(rsp_fault), .rsp_stall(rsp_stall),
    .rsp_paddr(rsp_paddr), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata)
  );

  // Memory model: acknowledges one cycle after a request is seen
  always @(posedge clk) begin
    if (rst) begin
      mem_ack <= 1'b0;
    end else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && !mem_ack) begin
        if (mem_we) begin
          pt_mem[mem_addr] = mem_wdata;
          n_wr <= n_wr + 1;
        end else begin
          mem_rdata    <= pt_mem.exists(mem_addr) ? pt_mem[mem_addr] : 32'h0;
          last_rd_addr <= mem_addr;
          n_rd <= n_rd + 1;
        end
      end
    end
  end

  function automatic logic [16:0] ppn_of(input logic [19:0] vpn);
    return vpn[16:0] + 17'h00200;
  endfunction

  function automatic logic [31:0] word_addr(input logic [19:0] vpn);
    return BASE + {10'd0, vpn, 2'b00};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One translation; expectations: table reads, table writes, fault
  task automatic access(input bit wr, input logic [19:0] vpn, input logic [11:0] ofs,
                        input int exp_rd, input int exp_wb, input bit exp_flt,
                        input bit flush_on_ack);
    int rd0 = n_rd;
    int wr0 = n_wr;
    int cyc = 0;
    bit saw_stall = 1'b0;
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_vaddr = {vpn, ofs};
    do begin
      @(negedge clk);
      cyc++;
      flush = 1'b0;
      if (rsp_stall) saw_stall = 1'b1;
      if (flush_on_ack && mem_ack && !mem_we) flush = 1'b1;
    end while (!rsp_ready && !rsp_fault && cyc < 200);
    req_valid = 1'b0;
    chk(cyc < 200, "R3 response timeout", cyc, 200);
    chk(rsp_fault == exp_flt, "R5 fault flag", rsp_fault, exp_flt);
    chk(rsp_ready == !exp_flt, "R5 ready vs fault", rsp_ready, !exp_flt);
    if (!exp_flt)
      chk(rsp_paddr == {ppn_of(vpn), ofs}, "R1 physical address",
          rsp_paddr, {ppn_of(vpn), ofs});
    chk(n_rd - rd0 == exp_rd, "R7 table reads (R3/R4)", n_rd - rd0, exp_rd);
    chk(n_wr - wr0 == exp_wb, "R6 table writes", n_wr - wr0, exp_wb);
    chk(saw_stall == (exp_rd + exp_wb > 0), "R3 stall", saw_stall, exp_rd + exp_wb > 0);
    if (exp_rd > 0)
      chk(last_rd_addr == word_addr(vpn), "R3 walk address", last_rd_addr, word_addr(vpn));
    if (exp_rd == 0 && exp_wb == 0)
      chk(cyc == 1, "R2 hit latency", cyc, 1);
  endtask

  // {wr, vpn, ofs, reads, writes, fault}
  localparam int NV = 22;
  localparam logic [35:0] VEC [NV] = '{
    {1'b0, V0,          12'h123, 3'b100},  // miss, slot 0
    {1'b0, V0,          12'hFFF, 3'b000},  // hit
    {1'b1, V0,          12'h000, 3'b010},  // write to clean: write-back
    {1'b1, V0,          12'h004, 3'b000},  // now dirty
    {1'b1, V0 + 20'd1,  12'h010, 3'b100},  // word already dirty
    {1'b0, VFLT,        12'h020, 3'b101},  // not resident
    {1'b1, VFLT,        12'h024, 3'b101},  // still not cached
    {1'b1, V0 + 20'd2,  12'h030, 3'b110},  // miss + write-back
    {1'b0, V0 + 20'd3,  12'h040, 3'b100},
    {1'b0, V0 + 20'd4,  12'h050, 3'b100},
    {1'b0, V0 + 20'd5,  12'h060, 3'b100},
    {1'b0, V0 + 20'd6,  12'h070, 3'b100},
    {1'b0, V0 + 20'd7,  12'h080, 3'b100},  // all 8 full
    {1'b0, V0 + 20'd8,  12'h090, 3'b100},  // evicts slot 0 (V0)
    {1'b0, V0 + 20'd2,  12'h0A0, 3'b000},
    {1'b0, V0,          12'h0B0, 3'b100},  // evicts slot 1
    {1'b0, V0 + 20'd1,  12'h0C0, 3'b100},  // evicts slot 2
    {1'b0, V0 + 20'd3,  12'h0D0, 3'b000},  // slot 3 kept
    {1'b1, V0,          12'h0E0, 3'b000},  // dirty came back from table
    {1'b0, V0 + 20'd2,  12'h0F0, 3'b100},  // evicts slot 3
    {1'b0, V0 + 20'd3,  12'h100, 3'b100},  // evicts slot 4
    {1'b0, V0 + 20'd5,  12'h110, 3'b000}
  };

  task automatic load_base();
    @(negedge clk);
    base_we  = 1'b1;
    base_val = BASE | 32'h3;   // low bits must be ignored (R11)
    @(negedge clk);
    base_we  = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 9; i++)
      pt_mem[word_addr(V0 + 20'(i))] = {1'b1, (i == 1), 13'd0, ppn_of(V0 + 20'(i))};
    pt_mem[word_addr(VFLT)] = {1'b0, 1'b0, 13'd0, 17'h00ABC};

    repeat (3) @(negedge clk);
    chk(!rsp_ready && !rsp_fault && !rsp_stall && !mem_req, "R9 reset outputs",
        {rsp_ready, rsp_fault, rsp_stall, mem_req}, 0);
    rst = 1'b0;
    load_base();

    for (int i = 0; i < NV; i++)
      access(VEC[i][35], VEC[i][34:15], VEC[i][14:3], int'(VEC[i][2]),
             int'(VEC[i][1]), VEC[i][0], 1'b0);

    chk(pt_mem[word_addr(V0)] == {2'b11, 13'd0, ppn_of(V0)}, "R6 written word V0",
        pt_mem[word_addr(V0)], {2'b11, 13'd0, ppn_of(V0)});
    chk(pt_mem[word_addr(V0 + 20'd2)] == {2'b11, 13'd0, ppn_of(V0 + 20'd2)},
        "R6 written word V2", pt_mem[word_addr(V0 + 20'd2)],
        {2'b11, 13'd0, ppn_of(V0 + 20'd2)});

    // R8: flush drops everything
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    access(1'b0, V0 + 20'd5, 12'h200, 1, 0, 1'b0, 1'b0);
    access(1'b0, V0 + 20'd5, 12'h204, 0, 0, 1'b0, 1'b0);
    // R8: flush on the install edge wins
    access(1'b0, V0 + 20'd6, 12'h300, 1, 0, 1'b0, 1'b1);
    access(1'b0, V0 + 20'd6, 12'h304, 1, 0, 1'b0, 1'b0);
    access(1'b0, V0 + 20'd6, 12'h308, 0, 0, 1'b0, 1'b0);

    // R9: mid-run reset invalidates entries and clears the base
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    @(negedge clk); rst = 1'b0;
    chk(!rsp_ready && !rsp_stall && !mem_req, "R9 outputs after reset",
        {rsp_ready, rsp_stall, mem_req}, 0);
    load_base();
    access(1'b0, V0 + 20'd6, 12'h40C, 1, 0, 1'b0, 1'b0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL R3 watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule